// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block holds a short queue of one-byte completion records for a network transmitter. Each time the transmit engine finishes a frame it pushes one record. The host sees the oldest record on a byte-wide status port. Writing to that port removes the record. The queue depth is a parameter with a default of four. When a push arrives and the queue is already full, the new record is dropped. The loss is then marked on the newest record that is still stored.

The block also holds the transmitter off after certain faults. A jabber or underrun record, or a FIFO overrun signalled by the engine, keeps the transmit-disable output high until a transmitter reset is issued. An overrun also raises an adapter-failure flag. A one-cycle interrupt pulse marks every push whose record asks for host attention.

Top module: `tx_status_stack`

## Requirements
- R1: A stored record is built from the pushed byte as follows. Bit 7 (done) is forced to 1. Bits 6 to 3 are copied from `pushStatus[6:3]`: bit 6 is interrupt-on-success, bit 5 jabber, bit 4 underrun and bit 3 collision limit. Bit 2 (lost record) is 0 when the record is stored. Bits 1 and 0 are always 0. Input bits 7, 2, 1 and 0 are ignored.
- R2: Records leave in the order they were pushed. A record pushed at a clock edge appears on `statusByte` right after that edge if the queue was empty.
- R3: A `hostWr` at a clock edge removes the head record. A `hostWr` while the queue is empty has no effect.
- R4: While the queue is empty, `statusByte` reads 0x00, so bit 7 is clear. This includes the state after reset.
- R5: A push while `DEPTH` records are held and no `hostWr` is given at the same edge is dropped. Bit 2 is then set on the newest stored record, and the other stored records are left unchanged.
- R6: A push and a `hostWr` at the same edge on a full queue are both carried out, and no lost-record mark is made.
- R7: A pushed record with bit 5 or bit 4 set drives `txDisable` high from the next cycle. It stays high until a `txReset` edge. If a new fault push and `txReset` occur at the same edge, the fault wins.
- R8: `txOverrun` drives `adapterFail` and `txDisable` high from the next cycle until a `txReset` edge.
- R9: `txIntPulse` is high for exactly the one cycle after a push whose bits 6 to 3 are not all zero. This holds even if that push is dropped.
- R10: `txReset` does not change the contents of the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; empties the queue and clears all latches |
| pushValid | input | 1 | Transmit engine delivers a completion record |
| pushStatus | input | 8 | Raw record bits from the engine (bits 6:3 used) |
| hostWr | input | 1 | Host write to the status port; removes the head |
| statusByte | output | 8 | Head record, 0x00 when empty |
| txReset | input | 1 | Transmitter reset command |
| txOverrun | input | 1 | Transmit FIFO overrun condition from the engine |
| txDisable | output | 1 | Transmitter held off |
| adapterFail | output | 1 | Adapter failure after overrun |
| txIntPulse | output | 1 | One-cycle completion interrupt |

## Verification
The bench fills the queue to its limit and pushes once more. A design that overwrote the oldest record, or marked the wrong slot, would show a bad byte when the queue is drained. A push together with a pop on a full queue is checked to be accepted: a design that tested fullness before the pop would drop it and report a false loss. The bench also issues a reset command at the same edge as a new underrun, where the fault must win, and pops an empty queue, where the pointers must not move. A design that gated the interrupt on acceptance would miss the pulse for a dropped push.

// File: rtl/txstk_pkg.sv
package txstk_pkg;
  localparam int BIT_DONE = 7;
  localparam int BIT_IRQ  = 6;
  localparam int BIT_JAB  = 5;
  localparam int BIT_UND  = 4;
  localparam int BIT_MAXC = 3;
  localparam int BIT_LOST = 2;

  typedef struct packed {
    logic push;     // store a new record at the tail
    logic pop;      // retire the head record
    logic markLost; // flag the newest stored record
  } stackCtl_t;

  function automatic logic [7:0] makeEntry(input logic [7:0] raw);
    logic [7:0] e;
    e = 8'h00;
    e[BIT_DONE] = 1'b1;
    e[BIT_IRQ]  = raw[BIT_IRQ];
    e[BIT_JAB]  = raw[BIT_JAB];
    e[BIT_UND]  = raw[BIT_UND];
    e[BIT_MAXC] = raw[BIT_MAXC];
    return e;
  endfunction
endpackage

// File: rtl/txstk_ctrl.sv
module txstk_ctrl
  import txstk_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pushValid,
  input  logic [7:0] pushStatus,
  input  logic       hostWr,
  input  logic       txReset,
  input  logic       txOverrun,
  output stackCtl_t  ctl,
  output logic       isEmpty,
  output logic       txDisable,
  output logic       adapterFail,
  output logic       txIntPulse
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count;
  logic isFull, doPop, doPush, faultPush, attnPush;
  logic errLatch, ovrLatch;

  assign isEmpty   = (count == '0);
  assign isFull    = (count == FULL_CNT);
  assign doPop     = hostWr && !isEmpty;
  assign doPush    = pushValid && (!isFull || doPop);
  assign faultPush = pushValid && (pushStatus[BIT_JAB] || pushStatus[BIT_UND]);
  assign attnPush  = pushValid && (|pushStatus[BIT_IRQ:BIT_MAXC]);

  always_comb begin
    ctl.push     = doPush;
    ctl.pop      = doPop;
    ctl.markLost = pushValid && isFull && !doPop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errLatch   <= 1'b0;
      ovrLatch   <= 1'b0;
      txIntPulse <= 1'b0;
    end else begin
      txIntPulse <= attnPush;
      if (faultPush)    errLatch <= 1'b1;
      else if (txReset) errLatch <= 1'b0;
      if (txOverrun)    ovrLatch <= 1'b1;
      else if (txReset) ovrLatch <= 1'b0;
    end
  end

  assign txDisable   = errLatch || ovrLatch;
  assign adapterFail = ovrLatch;

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);
  // R3
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && isEmpty && !pushValid) |=> isEmpty);
  // R7
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultPush |=> txDisable);
  // R8
  overrun_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    txOverrun |=> (adapterFail && txDisable));
  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    attnPush |=> txIntPulse);
  // R6
  full_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && hostWr && isFull) |=> isFull);
endmodule

// File: rtl/txstk_data.sv
module txstk_data
  import txstk_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  stackCtl_t  ctl,
  input  logic       isEmpty,
  input  logic [7:0] pushStatus,
  output logic [7:0] headByte
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [7:0]       slots [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, newestPtr;
  logic [7:0]       newEntry;

  assign newEntry  = makeEntry(pushStatus);
  assign newestPtr = (wrPtr == '0) ? LAST : wrPtr - 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (ctl.push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (ctl.pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slots[i] <= 8'h00;
      end else if (ctl.push && wrPtr == PTR_W'(i)) begin
        slots[i] <= newEntry;
      end else if (ctl.markLost && newestPtr == PTR_W'(i)) begin
        slots[i][BIT_LOST] <= 1'b1;
      end
    end
  end

  assign headByte = isEmpty ? 8'h00 : slots[rdPtr];

  // R1
  head_format_chk: assert property (@(posedge clk) disable iff (!rstN)
    !isEmpty |-> (headByte[BIT_DONE] && headByte[1:0] == 2'b00));
  // R5
  lost_no_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.markLost |-> !ctl.push);
endmodule

// File: rtl/tx_status_stack.sv
module tx_status_stack
  import txstk_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pushValid,
  input  logic [7:0] pushStatus,
  input  logic       hostWr,
  output logic [7:0] statusByte,
  input  logic       txReset,
  input  logic       txOverrun,
  output logic       txDisable,
  output logic       adapterFail,
  output logic       txIntPulse
);
  stackCtl_t ctl;
  logic      isEmpty;

  txstk_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushStatus(pushStatus),
    .hostWr(hostWr), .txReset(txReset), .txOverrun(txOverrun),
    .ctl(ctl), .isEmpty(isEmpty), .txDisable(txDisable),
    .adapterFail(adapterFail), .txIntPulse(txIntPulse)
  );

  txstk_data #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .isEmpty(isEmpty),
    .pushStatus(pushStatus), .headByte(statusByte)
  );

  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isEmpty && !ctl.push) |=> (statusByte == 8'h00));
endmodule

// File: tb/tx_status_stack_test.sv
module tx_status_stack_test;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 1'b0;
  logic [7:0] pushStatus = 8'h00;
  logic hostWr = 1'b0;
  logic txReset = 1'b0;
  logic txOverrun = 1'b0;
  logic [7:0] statusByte;
  logic txDisable, adapterFail, txIntPulse;

  int nChk = 0;
  int nFail = 0;
  logic [7:0] model [$];

  always #4 clk = ~clk;

  tx_status_stack #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushStatus(pushStatus),
    .hostWr(hostWr), .statusByte(statusByte), .txReset(txReset),
    .txOverrun(txOverrun), .txDisable(txDisable), .adapterFail(adapterFail),
    .txIntPulse(txIntPulse)
  );

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expEntry(input logic [7:0] raw);
    return {1'b1, raw[6:3], 3'b000};
  endfunction

  function automatic logic [7:0] modelHead();
    return (model.size() == 0) ? 8'h00 : model[0];
  endfunction

  // Driver: one edge with optional push/pop, model updated, outputs compared.
  task automatic cycle(input logic doPush, input logic [7:0] raw,
                       input logic doPop, input string req);
    logic expIrq;
    logic [7:0] e;
    pushValid = doPush; pushStatus = raw; hostWr = doPop;
    @(negedge clk);
    pushValid = 1'b0; hostWr = 1'b0; pushStatus = 8'h00;
    if (doPop && model.size() != 0) void'(model.pop_front());
    if (doPush) begin
      if (model.size() < DEPTH) model.push_back(expEntry(raw));
      else begin
        e = model[model.size()-1];
        e[2] = 1'b1;
        model[model.size()-1] = e;
      end
    end
    expIrq = doPush && (|raw[6:3]);
    check({req, " irq"}, txIntPulse, expIrq);
    check({req, " head"}, statusByte, modelHead());
  endtask

  // Monitor: drains the design and compares every record with the model.
  task automatic drain(input string req);
    while (model.size() != 0) begin
      check({req, " drain"}, statusByte, model[0]);
      cycle(1'b0, 8'h00, 1'b1, req);
    end
    check({req, " empty"}, statusByte, 8'h00);
  endtask

  initial begin
    #200000;
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R4 reset state
    check("R4 reset head", statusByte, 8'h00);
    check("R7 reset disable", txDisable, 0);
    check("R8 reset fail", adapterFail, 0);
    // R3 pop on empty ignored
    cycle(1'b0, 8'h00, 1'b1, "R3 empty pop");
    cycle(1'b1, 8'h00, 1'b0, "R3 after empty pop");
    check("R3 single", statusByte, 8'h80);
    drain("R3");
    // R1 ignored bits, R2 order, R9 irq
    cycle(1'b1, 8'h87, 1'b0, "R1 ignored bits");
    cycle(1'b1, 8'h40, 1'b0, "R9 irq bit");
    cycle(1'b1, 8'h08, 1'b0, "R1 maxcoll");
    drain("R2");
    // R5 overflow
    for (int i = 0; i < DEPTH; i++) cycle(1'b1, 8'(i << 3), 1'b0, "R5 fill");
    cycle(1'b1, 8'h40, 1'b0, "R5 overflow irq");
    drain("R5");
    // R6 push+pop at full
    for (int i = 0; i < DEPTH; i++) cycle(1'b1, 8'h00, 1'b0, "R6 fill");
    cycle(1'b1, 8'h48, 1'b1, "R6 swap");
    drain("R6");
    // R7 jabber latches, reset clears, R10 queue kept
    cycle(1'b1, 8'h20, 1'b0, "R7 jabber");
    check("R7 disabled", txDisable, 1);
    txReset = 1'b1;
    cycle(1'b0, 8'h00, 1'b0, "R10 reset keeps queue");
    txReset = 1'b0;
    check("R7 cleared", txDisable, 0);
    check("R10 head kept", statusByte, 8'hA0);
    txReset = 1'b1;
    cycle(1'b1, 8'h10, 1'b0, "R7 underrun with reset");
    txReset = 1'b0;
    check("R7 fault wins", txDisable, 1);
    drain("R10");
    check("R7 still held", txDisable, 1);
    txReset = 1'b1; @(negedge clk); txReset = 1'b0;
    check("R7 released", txDisable, 0);
    // R8 overrun
    txOverrun = 1'b1; @(negedge clk); txOverrun = 1'b0;
    check("R8 fail", adapterFail, 1);
    check("R8 disable", txDisable, 1);
    @(negedge clk);
    check("R8 held", adapterFail, 1);
    txReset = 1'b1; @(negedge clk); txReset = 1'b0;
    check("R8 cleared", adapterFail, 0);
    check("R8 enabled", txDisable, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule